// File: doc/BRIEF.md
# Dual-Mode 32-bit Interval Timer

This block is a 32-bit up-counter that software drives through a narrow register bus with simple read and write strobes. One counter serves three uses. It can run free over the whole 32-bit range as a time base. It can restart on every match with a programmed terminal value and flag an interrupt each time, which is periodic mode. It can also make a single pass up to the terminal value when a trigger bit is set, which is one-shot mode.

The bus is half the counter width, so the terminal value and the live count are each split into a low half and a high half. Reading the low half of the count copies the high half into a holding register. A later read of the high half returns that copy, so software gets a coherent 32-bit value from two reads even while the counter keeps moving. The interrupt line is a sticky status flag that software clears by writing a one to it.

Registers sit on a 4-byte stride: the byte address is four times the register index, and address bits [1:0] are ignored.

Top module: `interval_timer`

## Requirements
- R1: After reset every register holds zero, `irq` is low and `rdata` is zero.
- R2: Register indices are: 0 control, 1 status, 2 terminal low half, 3 terminal high half, 4 count low half, 5 count high half. Control bits are: bit 0 run, bit 1 trigger, bit 2 clear, bit 3 capture, bit 8 interrupt enable. Status bit 8 is the interrupt flag. Both terminal halves read back what was written. Read data appears on `rdata` in the cycle after the read strobe.
- R3: While run or trigger is set, the count rises by one per clock. In the cycle where the count equals the terminal value it returns to zero instead, so one period is terminal+1 clocks.
- R4: Each return to zero with interrupt enable set raises the status flag, and `irq` follows the flag. In periodic mode `irq` first rises terminal+1 clocks after the control write.
- R5: A read of the count low half copies the count high half into a holding register. A read of the count high half returns the held copy, not the live value.
- R6: Writing control with the capture bit set also copies the count high half into the holding register. The clear and capture bits read back as zero.
- R7: Writing control with the clear bit set forces the count to zero on that write's clock edge, ahead of any increment.
- R8: With trigger set and run clear, the counter makes one pass to the terminal value. On the expiry clock the trigger bit clears itself, the count goes to zero and stays there, and the flag is set exactly once.
- R9: When software clears both run and trigger, the count holds its value. A pending one-shot that is cancelled this way never raises the flag.
- R10: Writing status with bit 8 set clears the flag. If that write lands in the same clock as an expiry with interrupt enable set, the flag stays set.
- R11: With run set and terminal value 0xFFFFFFFF, the count carries from the low half into the high half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW (5) | Byte address; bits [AW-1:2] select the register |
| wdata | input | BW (16) | Write data |
| rdata | output | BW (16) | Registered read data |
| irq | output | 1 | Interrupt level (status flag) |

## Verification
The hardest case to reach from the ports is the torn read. This needs a low-half read at the exact clock where the count low half is 0xFFFF, followed by a high-half read after the carry has already happened.

The bench runs a cycle counter from the edge that starts the counter with a clear. It computes the count that every read will sample and releases the low-half read on the one cycle that samples 0xFFFF. A high-half read ten cycles later must then return the held 0, not the live 1.

The same cycle arithmetic places a flag-clearing write on the exact expiry edge, to show that expiry wins the collision.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  // register indices (byte address = 4 * index)
  localparam int IX_CTRL   = 0;
  localparam int IX_STAT   = 1;
  localparam int IX_MAX_LO = 2;
  localparam int IX_MAX_HI = 3;
  localparam int IX_CNT_LO = 4;
  localparam int IX_CNT_HI = 5;

  // control / status bit positions
  localparam int B_RUN  = 0;
  localparam int B_TRIG = 1;
  localparam int B_CLR  = 2;
  localparam int B_CAP  = 3;
  localparam int B_IE   = 8;
  localparam int B_FLAG = 8;

  typedef struct packed {
    logic ie;
    logic trig;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/timer_core.sv
module timer_core #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          trig_en,
  input  logic          clr_now,
  input  logic [CW-1:0] max_val,
  output logic [CW-1:0] cnt,
  output logic          expire
);
  // next count: wrap to zero on terminal match
  function automatic logic [CW-1:0] step(input logic [CW-1:0] cur,
                                         input logic [CW-1:0] lim);
    return (cur == lim) ? '0 : cur + 1'b1;
  endfunction

  logic running;
  assign running = run_en | trig_en;
  assign expire  = running && (cnt == max_val);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clr_now) cnt <= '0;
    else if (running) cnt <= step(cnt, max_val);
  end

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == '0));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !expire && !clr_now) |=> (cnt == $past(cnt) + 1'b1));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !clr_now) |=> $stable(cnt));
  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> (cnt == '0));
endmodule

// File: rtl/timer_irq.sv
module timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ie,
  input  logic w1c,
  output logic flag
);
  logic fire;
  assign fire = expire & ie;

  always_ff @(posedge clk) begin
    if (!rst_n)    flag <= 1'b0;
    else if (fire) flag <= 1'b1;   // expiry beats a clearing write
    else if (w1c)  flag <= 1'b0;
  end

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag);
  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c && !fire) |=> !flag);
  p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !w1c) |=> flag);
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import itmr_pkg::*;
#(
  parameter int BW = 16,
  parameter int AW = 5,
  parameter int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  input  logic [CW-1:0] cnt,
  input  logic          expire,
  input  logic          flag,
  output ctrl_t         ctrl,
  output logic          clr_now,
  output logic          w1c,
  output logic [CW-1:0] max_val,
  output logic [BW-1:0] rdata
);
  localparam int IW = AW - 2;

  function automatic logic [IW-1:0] ix(input int n);
    return IW'(n);
  endfunction

  logic [IW-1:0] idx;
  logic          wr_ctrl, rd_lo, snap, oneshot_done;
  logic [BW-1:0] hold, rd_mux;
  logic [1:0][BW-1:0] max_h;
  wire unused_addr = ^addr[1:0];

  assign idx          = addr[AW-1:2];
  assign wr_ctrl      = wr_en && (idx == ix(IX_CTRL));
  assign clr_now      = wr_ctrl && wdata[B_CLR];
  assign w1c          = wr_en && (idx == ix(IX_STAT)) && wdata[B_FLAG];
  assign rd_lo        = rd_en && (idx == ix(IX_CNT_LO));
  assign snap         = rd_lo || (wr_ctrl && wdata[B_CAP]);
  assign oneshot_done = expire && ctrl.trig;

  // terminal value halves
  for (genvar h = 0; h < 2; h++) begin : g_max
    localparam logic [IW-1:0] HIX = IW'(IX_MAX_LO + h);
    always_ff @(posedge clk) begin
      if (!rst_n)                     max_h[h] <= '0;
      else if (wr_en && idx == HIX)   max_h[h] <= wdata;
    end
  end
  assign max_val = {max_h[1], max_h[0]};

  // control register; trigger self-clears on one-shot expiry
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl.run  <= wdata[B_RUN];
      ctrl.trig <= wdata[B_TRIG];
      ctrl.ie   <= wdata[B_IE];
    end else if (oneshot_done) begin
      ctrl.trig <= 1'b0;
    end
  end

  // high-half holding register
  always_ff @(posedge clk) begin
    if (!rst_n)    hold <= '0;
    else if (snap) hold <= cnt[CW-1:BW];
  end

  always_comb begin
    rd_mux = '0;
    case (idx)
      ix(IX_CTRL): begin
        rd_mux[B_RUN]  = ctrl.run;
        rd_mux[B_TRIG] = ctrl.trig;
        rd_mux[B_IE]   = ctrl.ie;
      end
      ix(IX_STAT):   rd_mux[B_FLAG] = flag;
      ix(IX_MAX_LO): rd_mux = max_h[0];
      ix(IX_MAX_HI): rd_mux = max_h[1];
      ix(IX_CNT_LO): rd_mux = cnt[BW-1:0];
      ix(IX_CNT_HI): rd_mux = hold;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  p_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (hold == $past(cnt[CW-1:BW])));
  p_hiread_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx == ix(IX_CNT_HI)) |=> (rdata == $past(hold)));
  p_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot_done && !wr_ctrl) |=> !ctrl.trig);
  p_idle_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int BW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  output logic          irq
);
  localparam int CW = 2 * BW;

  ctrl_t         ctrl;
  logic          clr_now, w1c, expire, flag;
  logic [CW-1:0] max_val, cnt;

  timer_regs #(.BW(BW), .AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .cnt(cnt), .expire(expire), .flag(flag),
    .ctrl(ctrl), .clr_now(clr_now), .w1c(w1c), .max_val(max_val),
    .rdata(rdata)
  );

  timer_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .run_en(ctrl.run), .trig_en(ctrl.trig),
    .clr_now(clr_now), .max_val(max_val), .cnt(cnt), .expire(expire)
  );

  timer_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .ie(ctrl.ie),
    .w1c(w1c), .flag(flag)
  );

  assign irq = flag;
endmodule

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int errors = 0, checks = 0, cyc = 0, w0 = 0;
  logic rd_d = 1'b0;
  bit done = 1'b0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb_q[$];

  interval_timer i_interval_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) begin
    cyc  <= cyc + 1;
    rd_d <= rd_en;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each read result with the queued expectation
  always @(negedge clk) begin
    if (rd_d && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(rdata === it.exp, it.tag, rdata, it.exp);
    end
  end

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [4:0] a, input logic [15:0] e,
                        input string tag);
    sb_q.push_back('{e, tag});
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    check(irq === e, tag, {15'd0, irq}, {15'd0, e});
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
    end
  end

  initial begin
    wait_neg(3);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    check(rdata === 16'h0, "R1 rdata", rdata, 16'h0);
    rd_exp(5'h00, 16'h0000, "R1 ctrl");
    rd_exp(5'h10, 16'h0000, "R1 count");
    rd_exp(5'h04, 16'h0000, "R1 status");

    // R2 terminal halves read back
    wr(5'h0C, 16'hA5A5);
    rd_exp(5'h0C, 16'hA5A5, "R2 max hi");
    wr(5'h0C, 16'h0000);
    wr(5'h08, 16'h0004);
    rd_exp(5'h08, 16'h0004, "R2 max lo");

    // R3/R4/R10 periodic, period 5
    wr(5'h00, 16'h0101);                 // edge W
    wait_neg(4); chk_irq(1'b0, "R4 before first expiry");
    wait_neg(1); chk_irq(1'b1, "R3 first expiry at max+1");
    wr(5'h04, 16'h0100);                 // edge W+6
    chk_irq(1'b0, "R10 flag cleared");
    wait_neg(3); chk_irq(1'b0, "R3 mid period");
    wait_neg(1); chk_irq(1'b1, "R4 second expiry");
    wait_neg(4);
    wr(5'h04, 16'h0100);                 // edge W+15 = expiry
    chk_irq(1'b1, "R10 expiry wins over clear");
    wr(5'h04, 16'h0100);
    chk_irq(1'b0, "R10 clear after collision");
    wr(5'h00, 16'h0000);
    wr(5'h04, 16'h0100);

    // R8 one-shot to 3
    wr(5'h08, 16'h0003);
    wr(5'h00, 16'h0004);                 // clear count, idle
    wr(5'h00, 16'h0102);                 // edge T
    wait_neg(3); chk_irq(1'b0, "R8 before expiry");
    wait_neg(1); chk_irq(1'b1, "R8 expiry");
    rd_exp(5'h00, 16'h0100, "R8 trigger self-clears");
    rd_exp(5'h10, 16'h0000, "R8 count parked at zero");
    wr(5'h04, 16'h0100);
    wait_neg(20); chk_irq(1'b0, "R8 fires once");
    rd_exp(5'h04, 16'h0000, "R10 status clear");

    // R9 cancel a pending one-shot
    wr(5'h08, 16'h000A);
    wr(5'h00, 16'h0102);                 // edge T
    wait_neg(3);
    wr(5'h00, 16'h0100);                 // edge T+4, count 4
    wait_neg(20); chk_irq(1'b0, "R9 cancelled no irq");
    rd_exp(5'h10, 16'h0004, "R9 count held");
    rd_exp(5'h10, 16'h0004, "R9 count still held");

    // R7/R5/R6/R11 free run over full range
    wr(5'h08, 16'hFFFF);
    wr(5'h0C, 16'hFFFF);
    wr(5'h00, 16'h0005);                 // run + clear
    w0 = cyc;
    rd_exp(5'h10, 16'(cyc - w0), "R7 cleared count");
    wait_neg(7);
    rd_exp(5'h10, 16'(cyc - w0), "R3 free count");
    while (cyc != w0 + 65535) @(negedge clk);
    rd_exp(5'h10, 16'hFFFF, "R5 low read at FFFF");
    wait_neg(10);
    rd_exp(5'h14, 16'h0000, "R5 high half from snapshot");
    wr(5'h00, 16'h0009);                 // run + capture
    rd_exp(5'h14, 16'h0001, "R6 capture bit snapshot");
    rd_exp(5'h00, 16'h0001, "R6 clear/capture read zero");
    rd_exp(5'h10, 16'(cyc - w0), "R11 low half");
    rd_exp(5'h14, 16'h0001, "R11 carry into high half");

    wait_neg(3);
    done = 1'b1;
    summary();
  end
endmodule